// File: doc/BRIEF.md
# Character Relay Queue with Self-Starting Output

This block passes bytes from an input device to an output device through a small circular queue, so neither side waits on the other. Each input event brings one byte and a strobe. The block stores the byte, answers with a one-cycle status-clear pulse, and sends queued bytes to the output device one at a time. It starts a new output whenever the output device reports that the previous byte is done.

The output side has no separate start signal. When a byte arrives while the queue holds nothing, the block starts the output transaction itself. After that, every completion report from the output device pulls the next byte, if one is waiting. One storage slot is always left free, so a queue of `DEPTH` slots holds at most `DEPTH-1` bytes. An input that arrives with no room left is thrown away and sets an error flag that stays set until reset.

Neither side has back-pressure. The input strobe is never stalled: each strobe is either stored or dropped in the cycle it is seen. The output start is a single-cycle pulse, with the byte held steady on the data lines until the next start. The output device must not report completion for a transfer it was never given. A completion report that arrives while the queue is empty is ignored.

Top module: `char_relay_queue`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the occupancy is 0, `out_start` is 0, `in_clr` is 0 and `overflow_err` is 0.
- R2: Bytes leave on `out_data` in exactly the order in which they were accepted. The byte is valid in the cycle where `out_start` is 1.
- R3: With the default `DEPTH` of 8, the queue never holds more than 7 bytes, and `occupancy` never exceeds `DEPTH-1`.
- R4: An input strobe that finds the queue full, after any pop in the same cycle, is discarded and leaves the stored bytes unchanged. The cycle after it, `overflow_err` is 1. The flag then stays 1 until reset.
- R5: Every input strobe, whether accepted or dropped, gives `in_clr` = 1 in the following cycle. Cycles without a strobe give `in_clr` = 0.
- R6: An accepted input strobe, arriving with the queue empty and no completion report in the same cycle, gives `out_start` = 1 in the next cycle, with that byte on `out_data`. The occupancy stays 0.
- R7: A completion report (`out_done` = 1) with the queue non-empty gives `out_start` = 1 in the next cycle, with the oldest stored byte on `out_data`. The occupancy drops by one unless a byte is also accepted in that cycle.
- R8: A completion report with the queue empty has no effect: `out_start` stays 0 and `out_data` and the occupancy do not change.
- R9: When an input strobe and a completion report come in the same cycle, the pop takes effect before the push. On a full queue, the new byte is therefore accepted without error and the occupancy stays at `DEPTH-1`.
- R10: `occupancy` equals the number of bytes accepted and not yet sent. It stays correct across any number of pointer wraps.
- R11: `out_data` holds its value in every cycle in which `out_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input device has a byte this cycle |
| in_data | input | DATA_W | Byte from the input device |
| in_clr | output | 1 | One-cycle pulse clearing the input device status |
| out_data | output | DATA_W | Byte presented to the output device |
| out_start | output | 1 | One-cycle pulse starting an output transfer |
| out_done | input | 1 | Output device finished its transfer |
| occupancy | output | $clog2(DEPTH) | Bytes currently waiting in the queue |
| overflow_err | output | 1 | Sticky flag: an input byte was dropped |

## Verification
A directed sequence fills the queue starting from empty. It shows that the first byte goes straight out while the next seven are stored, and that the next strobe is dropped and sets the error flag. A strobe and a completion arrive together on a full queue, which separates pop-then-push ordering from the other order. Draining the queue checks the byte order, and a completion on an empty queue is shown to change nothing. Random phases weighted toward input, toward output, and balanced then drive the pointers through many wraps and repeated overflow. They also make empty-queue restarts happen often, all checked against a byte-queue model in the bench.

// File: rtl/relay_pkg.sv
package relay_pkg;

  // Where the byte for an output start comes from in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_QUEUE  = 2'd1,
    SRC_BYPASS = 2'd2
  } relay_src_e;

  // Decisions taken in one cycle
  typedef struct packed {
    logic accept;
    logic drop;
    logic pop_done;
    logic self_start;
  } relay_dec_t;

endpackage

// File: rtl/relay_ring_mem.sv
module relay_ring_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && waddr == PTR_W'(i)) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];

endmodule

// File: rtl/relay_ptrs.sv
module relay_ptrs #(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [PTR_W:0]   diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
      if (pop)  head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
    end
  end

  always_comb begin
    if (tail_q >= head_q) diff = {1'b0, tail_q} - {1'b0, head_q};
    else                  diff = (PTR_W+1)'(DEPTH) + {1'b0, tail_q} - {1'b0, head_q};
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign occ   = CNT_W'(diff);
  assign empty = (head_q == tail_q);

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, occ} <= (CNT_W+1)'(DEPTH - 1)); // R3
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> ({1'b0, occ} < (CNT_W+1)'(DEPTH - 1))); // R4
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (!empty || push)); // R8

endmodule

// File: rtl/relay_ctrl.sv
module relay_ctrl
  import relay_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_done,
  input  logic [CNT_W-1:0]  occ,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  output logic              push,
  output logic              pop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              in_clr,
  output logic              err
);

  localparam logic [CNT_W:0] CAP = (CNT_W+1)'(DEPTH - 1);

  relay_dec_t        dec;
  relay_src_e        src;
  logic [CNT_W:0]    occ_mid;
  logic [DATA_W-1:0] data_q;
  logic              start_q, clr_q, err_q;

  always_comb begin
    dec.pop_done   = out_done && !empty;
    // the pop from a completion counts before the push is judged
    occ_mid        = {1'b0, occ} - (CNT_W+1)'(dec.pop_done);
    dec.accept     = in_valid && (occ_mid < CAP);
    dec.drop       = in_valid && !dec.accept;
    dec.self_start = dec.accept && !dec.pop_done && empty;
    if (dec.pop_done)        src = SRC_QUEUE;
    else if (dec.self_start) src = SRC_BYPASS;
    else                     src = SRC_NONE;
  end

  assign push = dec.accept;
  assign pop  = dec.pop_done || dec.self_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= (src != SRC_NONE);
      clr_q   <= in_valid;
      if (dec.drop) err_q <= 1'b1;
      case (src)
        SRC_QUEUE:  data_q <= head_data;
        SRC_BYPASS: data_q <= in_data;
        default:    data_q <= data_q;
      endcase
    end
  end

  assign out_data  = data_q;
  assign out_start = start_q;
  assign in_clr    = clr_q;
  assign err       = err_q;

  AST_CLR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> in_clr); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R4
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> $past(in_valid || out_done)); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_start |-> $stable(out_data)); // R11

endmodule

// File: rtl/char_relay_queue.sv
module char_relay_queue #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      in_clr,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_start,
  input  logic                      out_done,
  output logic [$clog2(DEPTH)-1:0]  occupancy,
  output logic                      overflow_err
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  occ;
  logic              empty, push, pop;
  logic [DATA_W-1:0] head_data;

  relay_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .occ(occ), .empty(empty)
  );

  relay_ring_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .we(push), .waddr(tail), .wdata(in_data),
    .raddr(head), .rdata(head_data)
  );

  relay_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_done(out_done), .occ(occ), .empty(empty), .head_data(head_data),
    .push(push), .pop(pop), .out_data(out_data), .out_start(out_start),
    .in_clr(in_clr), .err(overflow_err)
  );

  assign occupancy = occ;

endmodule

// File: tb/sim_char_relay_queue.sv
module sim_char_relay_queue;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, out_done;
  logic [7:0] in_data;
  logic       in_clr, out_start, overflow_err;
  logic [7:0] out_data;
  logic [2:0] occupancy;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0] mq[$];
  bit         m_err, m_start, m_clr;
  logic [7:0] m_data;

  always #4 clk = ~clk;

  char_relay_queue #(.DEPTH(DEPTH), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_clr(in_clr), .out_data(out_data), .out_start(out_start),
    .out_done(out_done), .occupancy(occupancy), .overflow_err(overflow_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_step(input bit v, input logic [7:0] d, input bit dn);
    bit popped = 0;
    m_start = 0;
    m_clr   = v;
    if (dn && mq.size() > 0) begin
      m_data  = mq.pop_front();
      m_start = 1;
      popped  = 1;
    end
    if (v) begin
      if (mq.size() < DEPTH - 1) begin
        mq.push_back(d);
        if (!popped && mq.size() == 1) begin
          m_data  = mq.pop_front();
          m_start = 1;
        end
      end else begin
        m_err = 1;
      end
    end
  endfunction

  task automatic step(input bit v, input logic [7:0] d, input bit dn, input string tag);
    in_valid = v;
    in_data  = d;
    out_done = dn;
    model_step(v, d, dn);
    @(negedge clk);
    chk(out_start == m_start, tag, out_start, m_start);
    if (m_start) chk(out_data == m_data, "R2", out_data, m_data);
    else         chk(out_data == m_data, "R11", out_data, m_data);
    chk(in_clr == m_clr, "R5", in_clr, m_clr);
    chk(overflow_err == m_err, "R4", overflow_err, m_err);
    chk(occupancy == mq.size(), "R10", occupancy, mq.size());
    chk(occupancy <= DEPTH - 1, "R3", occupancy, DEPTH - 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; out_done = 0; in_data = '0;
    mq.delete(); m_err = 0; m_start = 0; m_clr = 0; m_data = '0;
    repeat (3) @(negedge clk);
    chk(occupancy == 0 && out_start == 0 && overflow_err == 0 && in_clr == 0,
        "R1", {occupancy, out_start, overflow_err, in_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(occupancy == 0 && out_start == 0 && overflow_err == 0 && in_clr == 0,
        "R1", {occupancy, out_start, overflow_err, in_clr}, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2718);
    do_reset();

    // directed: self-start into empty queue
    step(1, 8'hA0, 0, "R6");
    // fill to capacity
    for (int i = 1; i < 8; i++) step(1, 8'hA0 + 8'(i), 0, "R6");
    // overflow: byte dropped, sticky error
    step(1, 8'hEE, 0, "R4");
    step(0, 8'h00, 0, "R4");
    // simultaneous push and pop on full queue
    step(1, 8'hB0, 1, "R9");
    // drain in order
    for (int i = 0; i < 7; i++) step(0, 8'h00, 1, "R7");
    // completion on empty queue does nothing
    step(0, 8'h00, 1, "R8");
    step(0, 8'h00, 1, "R8");
    // completion with empty queue and a new byte together
    step(1, 8'hC0, 1, "R6");

    // random phases, fresh reset so the error flag can be watched again
    do_reset();
    for (int ph = 0; ph < 12; ph++) begin
      int unsigned pin, pout;
      case (ph % 3)
        0: begin pin = 75; pout = 25; end
        1: begin pin = 25; pout = 75; end
        default: begin pin = 50; pout = 50; end
      endcase
      for (int c = 0; c < 300; c++) begin
        bit v, dn;
        v  = ($urandom % 100) < pin;
        dn = ($urandom % 100) < pout;
        step(v, 8'($urandom), dn, dn ? "R7" : "R6");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule